// File: doc/BRIEF.md
# DDR Bank Command Legality Tracker

This block watches a DDR SDRAM command bus from the side and keeps its own model of each bank. At every rising clock edge it samples clock enable, chip select, the three command strobes, the bank address and address bit 8, and decodes the command. It then updates each bank's state and its minimum-delay counters, and raises a flag when the command breaks a rule for the bank it addresses or for the whole device. All timing limits are inputs, given in clock cycles, so one build serves any speed grade.

The flag is a one-cycle registered pulse that appears the cycle after the offending command, with a 3-bit code that gives the reason. An illegal command changes no tracked state. Per-bank status outputs show which banks are idle and which hold an open row.

Top module: `ddr_bank_guard`

## Requirements
- R1: A command is taken only when clock enable is high and chip select is low. Deselect (chip select high), clock enable low, NOP (strobes RAS/CAS/WE = H,H,H) and burst stop (H,H,L), when outside a mode or refresh window, never raise the flag and change no state.
- R2: The strobe codes (RAS,CAS,WE, active low) are: L,H,H activate; H,L,H read; H,L,L write; L,H,L precharge; L,L,H refresh; L,L,L mode set. An activate to a bank that is not idle is flagged: reason 5 when the bank is still closing, otherwise reason 1. A read or write to a bank without an open row is flagged the same way.
- R3: A read or write to an open bank earlier than t_rcd cycles after its activate is flagged with reason 2. At exactly t_rcd cycles it is legal.
- R4: A precharge of an open bank earlier than t_ras cycles after its activate is flagged with reason 3. Precharge-all (A8 high, bank address ignored) is flagged with reason 3 when any open bank has not yet met t_ras.
- R5: An activate earlier than t_rrd cycles after the previous legal activate to any bank is flagged with reason 4.
- R6: A legal precharge closes the bank, which counts as idle again t_rp cycles later. A single-bank precharge (A8 low) of a bank without an open row is legal and has no effect.
- R7: A read with A8 high, issued at cycle n, leaves the bank closing until cycle n + burst_half + t_rp. A write with A8 high leaves it closing until n + burst_half + 1 + t_wr + t_rp.
- R8: After a legal mode set, every command other than NOP or deselect is flagged with reason 6 for t_mrd cycles. After a legal refresh, every such command is flagged with reason 1 for t_rc cycles.
- R9: A mode set or a refresh while any bank is not idle is flagged with reason 7.
- R10: The flag and the reason are registered and appear one cycle after the command. The reason is 0 whenever the flag is low. Reset clears the flag and makes all banks idle, with every counter expired.
- R11: bank_open shows the banks that hold an open row and bank_idle shows the banks that accept an activate. Both are updated on the edge that takes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; commands are taken only when it is high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NB) | Bank address |
| a8 | input | 1 | Auto-precharge on read/write; all-banks select on precharge |
| t_rcd | input | CW | Activate to read/write delay, cycles |
| t_ras | input | CW | Activate to precharge delay, cycles |
| t_rp | input | CW | Precharge duration, cycles |
| t_rrd | input | CW | Activate to activate delay, cycles |
| t_wr | input | CW | Write recovery, cycles |
| t_mrd | input | CW | Mode set busy window, cycles |
| t_rc | input | CW | Refresh busy window, cycles |
| burst_half | input | CW | Burst length divided by two |
| illegal | output | 1 | Registered pulse marking an illegal command |
| reason | output | 3 | Reason code for the flag; 0 when the flag is low |
| bank_idle | output | NB | One bit per bank: bank accepts an activate |
| bank_open | output | NB | One bit per bank: bank holds an open row |

## Verification
The bench builds the block with its default four banks and 6-bit counters. It drives small timing values (t_rcd 3, t_ras 5, t_rp 3, t_rrd 2, t_wr 2, t_mrd 2, t_rc 4, burst_half 2), so every delay window closes within a few cycles. That lets the bench hit both the last flagged cycle and the first legal cycle of each window, including the two auto-precharge windows. Short windows also let one run cover precharge-all with a partly satisfied t_ras, and refresh or mode set while some bank is still closing.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MRS  = 3'd6,
        CMD_BST  = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_STATE   = 3'd1,
        RSN_RCD     = 3'd2,
        RSN_RAS     = 3'd3,
        RSN_RRD     = 3'd4,
        RSN_RP      = 3'd5,
        RSN_MRD     = 3'd6,
        RSN_ALLIDLE = 3'd7
    } reason_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_trk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NONE;
                3'b110: cmd = CMD_BST;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_trk_pkg::*;
#(
    parameter int CW = 6,
    parameter int BW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          close_go,
    input  logic [BW-1:0] close_load,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_ras,
    output logic          is_idle,
    output logic          is_open,
    output logic          is_closing,
    output logic          rcd_done,
    output logic          ras_done
);
    typedef struct packed {
        bank_e         st;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [BW-1:0] busy;
    } bank_s;

    bank_s bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (bk_q.rcd != '0)  bk_d.rcd  = bk_q.rcd - 1'b1;
        if (bk_q.ras != '0)  bk_d.ras  = bk_q.ras - 1'b1;
        if (bk_q.busy != '0) bk_d.busy = bk_q.busy - 1'b1;
        if (bk_q.st == BK_CLOSING && bk_q.busy == '0) bk_d.st = BK_IDLE;
        if (act_go) begin
            bk_d.st  = BK_OPEN;
            bk_d.rcd = (t_rcd == '0) ? '0 : t_rcd - 1'b1;
            bk_d.ras = (t_ras == '0) ? '0 : t_ras - 1'b1;
        end
        if (close_go) begin
            bk_d.st   = BK_CLOSING;
            bk_d.busy = close_load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '{st: BK_IDLE, rcd: '0, ras: '0, busy: '0};
        end else begin
            bk_q <= bk_d;
        end
    end

    assign is_idle    = (bk_q.st == BK_IDLE) || (bk_q.st == BK_CLOSING && bk_q.busy == '0);
    assign is_open    = (bk_q.st == BK_OPEN);
    assign is_closing = (bk_q.st == BK_CLOSING) && (bk_q.busy != '0);
    assign rcd_done   = (bk_q.rcd == '0);
    assign ras_done   = (bk_q.ras == '0);
endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_trk_pkg::*;
#(
    parameter int NB  = 4,
    parameter int CW  = 6,
    localparam int BAW = (NB > 1) ? $clog2(NB) : 1,
    localparam int BW  = CW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cke,
    input  logic           cs_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic [BAW-1:0] ba,
    input  logic           a8,
    input  logic [CW-1:0]  t_rcd,
    input  logic [CW-1:0]  t_ras,
    input  logic [CW-1:0]  t_rp,
    input  logic [CW-1:0]  t_rrd,
    input  logic [CW-1:0]  t_wr,
    input  logic [CW-1:0]  t_mrd,
    input  logic [CW-1:0]  t_rc,
    input  logic [CW-1:0]  burst_half,
    output logic           illegal,
    output logic [2:0]     reason,
    output logic [NB-1:0]  bank_idle,
    output logic [NB-1:0]  bank_open
);
    typedef struct packed {
        logic [CW-1:0] rrd;
        logic [CW-1:0] mrd;
        logic [CW-1:0] rc;
        logic          flag;
        reason_e       rsn;
    } glob_s;

    glob_s g_d, g_q;
    cmd_e  cmd;

    logic [NB-1:0] bk_idle, bk_open, bk_closing, bk_rcd_ok, bk_ras_ok;
    logic [NB-1:0] act_go, close_go;
    logic [BW-1:0] close_load;

    logic [BW-1:0] rp_load, rdap_load, wrap_load;
    assign rp_load   = (t_rp == '0) ? '0 : BW'(t_rp) - 1'b1;
    assign rdap_load = BW'(burst_half) + BW'(t_rp) - 1'b1;
    assign wrap_load = BW'(burst_half) + BW'(t_wr) + BW'(t_rp);

    ddr_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ddr_bank_track #(.CW(CW), .BW(BW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_go     (act_go[b]),
            .close_go   (close_go[b]),
            .close_load (close_load),
            .t_rcd      (t_rcd),
            .t_ras      (t_ras),
            .is_idle    (bk_idle[b]),
            .is_open    (bk_open[b]),
            .is_closing (bk_closing[b]),
            .rcd_done   (bk_rcd_ok[b]),
            .ras_done   (bk_ras_ok[b])
        );
    end

    always_comb begin
        reason_e       rsn;
        logic [NB-1:0] sel;
        sel        = '0;
        sel[ba]    = 1'b1;
        rsn        = RSN_NONE;
        act_go     = '0;
        close_go   = '0;
        close_load = rp_load;
        g_d        = g_q;
        if (g_q.rrd != '0) g_d.rrd = g_q.rrd - 1'b1;
        if (g_q.mrd != '0) g_d.mrd = g_q.mrd - 1'b1;
        if (g_q.rc  != '0) g_d.rc  = g_q.rc  - 1'b1;

        if (cmd != CMD_NONE && g_q.mrd != '0) begin
            rsn = RSN_MRD;
        end else if (cmd != CMD_NONE && g_q.rc != '0) begin
            rsn = RSN_STATE;
        end else begin
            unique case (cmd)
                CMD_ACT: begin
                    if (!bk_idle[ba])      rsn = bk_closing[ba] ? RSN_RP : RSN_STATE;
                    else if (g_q.rrd != '0) rsn = RSN_RRD;
                    else begin
                        act_go  = sel;
                        g_d.rrd = (t_rrd == '0) ? '0 : t_rrd - 1'b1;
                    end
                end
                CMD_RD, CMD_WR: begin
                    if (!bk_open[ba])        rsn = bk_closing[ba] ? RSN_RP : RSN_STATE;
                    else if (!bk_rcd_ok[ba]) rsn = RSN_RCD;
                    else if (a8) begin
                        close_go   = sel;
                        close_load = (cmd == CMD_RD) ? rdap_load : wrap_load;
                    end
                end
                CMD_PRE: begin
                    if (a8) begin
                        if ((bk_open & ~bk_ras_ok) != '0) rsn = RSN_RAS;
                        else close_go = bk_open;
                    end else if (bk_open[ba]) begin
                        if (!bk_ras_ok[ba]) rsn = RSN_RAS;
                        else close_go = sel;
                    end
                end
                CMD_REF: begin
                    if (!(&bk_idle)) rsn = RSN_ALLIDLE;
                    else g_d.rc = (t_rc == '0) ? '0 : t_rc - 1'b1;
                end
                CMD_MRS: begin
                    if (!(&bk_idle)) rsn = RSN_ALLIDLE;
                    else g_d.mrd = (t_mrd == '0) ? '0 : t_mrd - 1'b1;
                end
                default: ;
            endcase
        end
        g_d.rsn  = rsn;
        g_d.flag = (rsn != RSN_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{rrd: '0, mrd: '0, rc: '0, flag: 1'b0, rsn: RSN_NONE};
        end else begin
            g_q <= g_d;
        end
    end

    assign illegal   = g_q.flag;
    assign reason    = g_q.rsn;
    assign bank_idle = bk_idle;
    assign bank_open = bk_open;
endmodule

// File: rtl/ddr_bank_guard_chk.sv
module ddr_bank_guard_chk #(
    parameter int NB  = 4,
    parameter int CW  = 6,
    parameter int BAW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cke,
    input logic           cs_n,
    input logic           ras_n,
    input logic           cas_n,
    input logic           we_n,
    input logic [CW-1:0]  t_rrd,
    input logic [CW-1:0]  t_mrd,
    input logic           illegal,
    input logic [2:0]     reason,
    input logic [NB-1:0]  bank_idle,
    input logic [NB-1:0]  bank_open
);
    logic taken, act_now, mrs_now;
    assign taken   = cke && !cs_n;
    assign act_now = taken && !ras_n && cas_n && we_n;
    assign mrs_now = taken && !ras_n && !cas_n && !we_n;

    // R10
    flag_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> reason != 3'd0);

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cke) |=> !illegal);

    // R11
    open_idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open & bank_idle) == '0);

    // R9
    mrs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_now && bank_open != '0) |=> (illegal && reason == 3'd7));

    // R5
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_now && t_rrd >= 2) ##1 (act_now && !illegal && $stable(t_rrd)) |=> illegal);

    // R8
    mrs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_now && t_mrd >= 2) ##1 (act_now && !illegal && $stable(t_mrd))
        |=> (illegal && reason == 3'd6));
endmodule

bind ddr_bank_guard ddr_bank_guard_chk #(.NB(NB), .CW(CW), .BAW(BAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .t_rrd     (t_rrd),
    .t_mrd     (t_mrd),
    .illegal   (illegal),
    .reason    (reason),
    .bank_idle (bank_idle),
    .bank_open (bank_open)
);

// File: tb/tb_ddr_bank_guard.sv
module tb_ddr_bank_guard;
    localparam int NB = 4;
    localparam int CW = 6;
    localparam int NV = 42;

    // codes: 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 REF 6 MRS 7 BST 8 DESEL 9 ACT with cke low
    // vector: {req[3:0], code[3:0], ba[1:0], a8, exp_flag, exp_reason[2:0]}
    localparam logic [14:0] VEC [NV] = '{
        {4'd9, 4'd6,2'd0,1'b0,1'b0,3'd0}, // 0  R9 MRS all idle legal
        {4'd8, 4'd1,2'd0,1'b0,1'b1,3'd6}, // 1  R8 ACT in mode window
        {4'd2, 4'd1,2'd0,1'b0,1'b0,3'd0}, // 2  R2 ACT b0
        {4'd5, 4'd1,2'd1,1'b0,1'b1,3'd4}, // 3  R5 ACT b1 too soon
        {4'd3, 4'd2,2'd0,1'b0,1'b1,3'd2}, // 4  R3 RD before t_rcd
        {4'd3, 4'd2,2'd0,1'b0,1'b0,3'd0}, // 5  R3 RD at t_rcd
        {4'd4, 4'd4,2'd0,1'b0,1'b1,3'd3}, // 6  R4 PRE before t_ras
        {4'd4, 4'd4,2'd0,1'b0,1'b0,3'd0}, // 7  R4 PRE at t_ras
        {4'd6, 4'd1,2'd0,1'b0,1'b1,3'd5}, // 8  R6 ACT while closing
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 9  R1 NOP
        {4'd6, 4'd1,2'd0,1'b0,1'b0,3'd0}, // 10 R6 ACT after t_rp
        {4'd9, 4'd6,2'd0,1'b0,1'b1,3'd7}, // 11 R9 MRS with open bank
        {4'd2, 4'd3,2'd1,1'b0,1'b1,3'd1}, // 12 R2 WR to idle bank
        {4'd5, 4'd1,2'd1,1'b0,1'b0,3'd0}, // 13 R5 ACT b1 after t_rrd
        {4'd1, 4'd7,2'd0,1'b0,1'b0,3'd0}, // 14 R1 burst stop
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 15 R1 NOP
        {4'd7, 4'd3,2'd1,1'b1,1'b0,3'd0}, // 16 R7 WR auto-precharge b1
        {4'd7, 4'd2,2'd0,1'b1,1'b0,3'd0}, // 17 R7 RD auto-precharge b0
        {4'd9, 4'd5,2'd0,1'b0,1'b1,3'd7}, // 18 R9 REF not all idle
        {4'd6, 4'd4,2'd2,1'b1,1'b0,3'd0}, // 19 R6 PRE all, none open
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 20 R1 NOP
        {4'd7, 4'd1,2'd0,1'b0,1'b1,3'd5}, // 21 R7 read AP window last cycle
        {4'd7, 4'd1,2'd0,1'b0,1'b0,3'd0}, // 22 R7 read AP window done
        {4'd7, 4'd1,2'd1,1'b0,1'b1,3'd5}, // 23 R7 write AP window last cycle
        {4'd7, 4'd1,2'd1,1'b0,1'b0,3'd0}, // 24 R7 write AP window done
        {4'd4, 4'd4,2'd3,1'b1,1'b1,3'd3}, // 25 R4 PRE all, t_ras pending
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 26 R1
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 27 R1
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 28 R1
        {4'd4, 4'd4,2'd3,1'b1,1'b0,3'd0}, // 29 R4 PRE all legal
        {4'd9, 4'd5,2'd0,1'b0,1'b1,3'd7}, // 30 R9 REF while closing
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 31 R1
        {4'd8, 4'd5,2'd0,1'b0,1'b0,3'd0}, // 32 R8 REF legal
        {4'd8, 4'd1,2'd2,1'b0,1'b1,3'd1}, // 33 R8 ACT in refresh window
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 34 R1
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}, // 35 R1
        {4'd8, 4'd1,2'd2,1'b0,1'b0,3'd0}, // 36 R8 ACT after t_rc
        {4'd1, 4'd8,2'd2,1'b0,1'b0,3'd0}, // 37 R1 deselect
        {4'd9, 4'd6,2'd0,1'b0,1'b1,3'd7}, // 38 R9 MRS with b2 open
        {4'd6, 4'd4,2'd3,1'b0,1'b0,3'd0}, // 39 R6 PRE idle bank
        {4'd1, 4'd9,2'd2,1'b0,1'b0,3'd0}, // 40 R1 cke low ignored
        {4'd1, 4'd0,2'd0,1'b0,1'b0,3'd0}  // 41 R1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, a8;
    logic [1:0] ba;
    logic [CW-1:0] t_rcd = 6'd3, t_ras = 6'd5, t_rp = 6'd3, t_rrd = 6'd2;
    logic [CW-1:0] t_wr = 6'd2, t_mrd = 6'd2, t_rc = 6'd4, burst_half = 6'd2;
    logic illegal;
    logic [2:0] reason;
    logic [NB-1:0] bank_idle, bank_open;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ddr_bank_guard #(.NB(NB), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a8(a8),
        .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_rrd(t_rrd), .t_wr(t_wr),
        .t_mrd(t_mrd), .t_rc(t_rc), .burst_half(burst_half),
        .illegal(illegal), .reason(reason), .bank_idle(bank_idle), .bank_open(bank_open)
    );

    task automatic drive(input logic [3:0] code, input logic [1:0] b, input logic a);
        cke = 1'b1; cs_n = 1'b0; ba = b; a8 = a;
        case (code)
            4'd1, 4'd9: {ras_n, cas_n, we_n} = 3'b011;
            4'd2:       {ras_n, cas_n, we_n} = 3'b101;
            4'd3:       {ras_n, cas_n, we_n} = 3'b100;
            4'd4:       {ras_n, cas_n, we_n} = 3'b010;
            4'd5:       {ras_n, cas_n, we_n} = 3'b001;
            4'd6:       {ras_n, cas_n, we_n} = 3'b000;
            4'd7:       {ras_n, cas_n, we_n} = 3'b110;
            4'd8: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
            default:    {ras_n, cas_n, we_n} = 3'b111;
        endcase
        if (code == 4'd9) cke = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        drive(4'd0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        // R10 reset state, R11 status after reset
        check("R10 reset flag", {31'd0, illegal}, 32'd0);
        check("R10 reset reason", {29'd0, reason}, 32'd0);
        check("R11 reset idle", {28'd0, bank_idle}, 32'hF);
        check("R11 reset open", {28'd0, bank_open}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10:7], VEC[i][6:5], VEC[i][4]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d flag", VEC[i][14:11], i), {31'd0, illegal}, {31'd0, VEC[i][3]});
            check($sformatf("R%0d vec%0d reason", VEC[i][14:11], i), {29'd0, reason}, {29'd0, VEC[i][2:0]});
        end

        // R11 status after the table: only bank 2 open, bank 2 not idle
        check("R11 open after table", {28'd0, bank_open}, 32'h4);
        check("R11 idle after table", {28'd0, bank_idle}, 32'hB);

        // R10 reset in the middle of activity clears banks
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset open", {28'd0, bank_open}, 32'h0);
        check("R10 mid reset idle", {28'd0, bank_idle}, 32'hF);
        rst_n = 1'b1;

        // R11 activate visible on the same edge, flag clear (R10)
        drive(4'd1, 2'd3, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R11 open after ACT", {28'd0, bank_open}, 32'h8);
        check("R10 legal ACT no flag", {31'd0, illegal}, 32'd0);
        drive(4'd0, 2'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        // R10 flag is a single-cycle pulse: write to idle bank 0 then NOP
        drive(4'd3, 2'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2 WR idle bank flag", {29'd0, reason}, 32'd1);
        drive(4'd0, 2'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R10 pulse ends", {31'd0, illegal}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule